// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block keeps the 64-bit floating-point control word and judges every finished floating-point or float-to-integer operation reported to it. Each report carries six exception indications and a flag telling whether the hardware could form the default result for an invalid operation. The block records the exceptions in sticky status bits. It then decides whether the operation must trap. If the trap is suppressed, it also decides which substitute value the destination receives: nothing, the default result defined by the floating-point standard, or a true +0.0.

Software reads the whole control word through a combinational read port and overwrites it through a single-cycle write strobe. The dynamic rounding mode held in the word is driven out continuously to the arithmetic units. Operation reports enter through a valid/ready stream. Verdicts leave through a second valid/ready stream that is held in a one-entry output register. A verdict waiting on a low `res_ready` holds its value and deasserts `evt_ready`, so back-pressure reaches the reporting pipeline in the same cycle. A report is taken only in a cycle where `evt_valid` and `evt_ready` are both high. Its verdict is presented on the next cycle.

Top module: `fpx_trap_ctl`

## Requirements
- R1: Reset clears the whole control word to zero and leaves no verdict pending (`res_valid` low).
- R2: A software write stores the written value into bits 61:49 of the control word. All other bits read as zero whatever is written. `sw_rdata` always shows the current word.
- R3: `rnd_mode` equals control bits 59:58. The encodings are 00 toward zero, 01 toward minus infinity, 10 round to nearest, and 11 toward plus infinity.
- R4: An accepted report sets control bit 52+k for each set bit k of `evt_flags`, whatever the disable bits hold. The `evt_flags` bits, from 0 upward, are invalid, divide-by-zero, overflow, underflow, inexact and integer overflow. These status bits are then kept until software writes them. When a write and an accepted report fall in the same cycle, the write is applied first and the report's flags are ORed onto it.
- R5: An underflow traps unless both bit 61 (underflow disable) and bit 60 (flush to zero) are set. With both set, there is no trap and the substitute is true zero. With bit 61 alone set, the report still traps, so that software can build a denormal.
- R6: An overflow with bit 51 set, or a divide-by-zero with bit 50 set, does not trap and selects the standard default result. With the matching bit clear, it traps.
- R7: An invalid operation does not trap only when bit 49 is set and `evt_dflt_ok` is high. In that case it selects the standard default result. Otherwise it traps.
- R8: Inexact and integer overflow never trap. A report carrying only these flags gives no trap and no substitute.
- R9: The substitute encoding on `res_subst` is 0 none, 1 standard default and 2 true zero. A trapping verdict always carries 0. A non-trapping verdict with an underflow carries 2 ahead of 1. The verdict is formed from the control word as it stood before any write in the acceptance cycle.
- R10: `evt_ready` is high when no verdict is pending or `res_ready` is high. A verdict appears with `res_valid` in the cycle after acceptance. A pending verdict that is not taken stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write value |
| sw_rdata | output | 64 | Current control word |
| evt_valid | input | 1 | Operation report valid |
| evt_ready | output | 1 | Operation report accepted when high with valid |
| evt_flags | input | 6 | Exception indications of the report (see R4) |
| evt_dflt_ok | input | 1 | Hardware can produce the invalid-operation default |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Consumer takes the verdict |
| res_trap | output | 1 | Trap request |
| res_subst | output | 2 | Substitute selector (see R9) |
| rnd_mode | output | 2 | Dynamic rounding mode (see R3) |

## Verification
The decision logic is driven with random reports in which each exception bit is set independently. Mixed into these are random control words, so every combination of disable bits meets single and multiple exceptions. This separates the two-bit underflow rule from the plain disable rules and shows when the invalid-operation default-ready input matters. Random `res_ready` stalls show whether a verdict is held and whether back-pressure blocks acceptance. Directed cases cover the all-ones write, a write coinciding with a report (which tells the write-first ordering apart from the old-word decision), and flags-only reports with inexact and integer overflow.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned NFLAG   = 6;
  localparam int unsigned FLAG_LO = 52;
  localparam int unsigned B_UNFD  = 61;
  localparam int unsigned B_UNDZ  = 60;
  localparam int unsigned B_RND   = 58;
  localparam int unsigned B_OVFD  = 51;
  localparam int unsigned B_DZED  = 50;
  localparam int unsigned B_INVD  = 49;
  localparam int unsigned LIVE_LO = 49;
  localparam int unsigned LIVE_HI = 61;

  localparam int unsigned F_INV = 0;
  localparam int unsigned F_DZE = 1;
  localparam int unsigned F_OVF = 2;
  localparam int unsigned F_UNF = 3;
  localparam int unsigned F_INE = 4;
  localparam int unsigned F_IOV = 5;

  typedef enum logic [1:0] {
    SUB_NONE = 2'd0,
    SUB_IEEE = 2'd1,
    SUB_ZERO = 2'd2
  } subst_t;

  typedef struct packed {
    logic unf_off;
    logic flush0;
    logic ovf_off;
    logic dz_off;
    logic inv_off;
  } dis_t;

  function automatic logic [WORD_W-1:0] live_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = LIVE_LO; i <= LIVE_HI; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpx_csr.sv
module fpx_csr
  import fpx_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_val,
  input  logic          set_en,
  input  logic [NF-1:0] set_flags,
  output logic [W-1:0]  word_q
);
  localparam logic [W-1:0] MASK = W'(live_mask());

  logic [W-1:0] base;
  logic [W-1:0] setv;

  always_comb begin
    base = wr_en ? (wr_val & MASK) : word_q;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_set
      if (g >= FLAG_LO && g < FLAG_LO + NF) begin : g_flag
        assign setv[g] = set_en & set_flags[g-FLAG_LO];
      end else begin : g_none
        assign setv[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= base | setv;
  end
endmodule

// File: rtl/fpx_decide.sv
module fpx_decide
  import fpx_pkg::*;
(
  input  dis_t             dis,
  input  logic [NFLAG-1:0] flags,
  input  logic             dflt_ok,
  output logic             trap,
  output subst_t           subst
);
  logic t_inv, t_dze, t_ovf, t_unf;
  logic any_dflt;

  always_comb begin
    t_unf = flags[F_UNF] & ~(dis.unf_off & dis.flush0);
    t_ovf = flags[F_OVF] & ~dis.ovf_off;
    t_dze = flags[F_DZE] & ~dis.dz_off;
    t_inv = flags[F_INV] & ~(dis.inv_off & dflt_ok);
    trap  = t_unf | t_ovf | t_dze | t_inv;
    any_dflt = flags[F_INV] | flags[F_DZE] | flags[F_OVF];
    if (trap)                subst = SUB_NONE;
    else if (flags[F_UNF])   subst = SUB_ZERO;
    else if (any_dflt)       subst = SUB_IEEE;
    else                     subst = SUB_NONE;
  end
endmodule

// File: rtl/fpx_outreg.sv
module fpx_outreg #(
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fpx_trap_ctl.sv
module fpx_trap_ctl
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] sw_rdata,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [NFLAG-1:0]  evt_flags,
  input  logic              evt_dflt_ok,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_trap,
  output logic [1:0]        res_subst,
  output logic [1:0]        rnd_mode
);
  logic [WORD_W-1:0] word;
  logic              accept;
  dis_t              dis;
  logic              d_trap;
  subst_t            d_subst;
  logic [2:0]        held;

  assign accept = evt_valid & evt_ready;

  fpx_csr #(.W(WORD_W), .NF(NFLAG)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sw_we), .wr_val(sw_wdata),
    .set_en(accept), .set_flags(evt_flags),
    .word_q(word)
  );

  assign dis.unf_off = word[B_UNFD];
  assign dis.flush0  = word[B_UNDZ];
  assign dis.ovf_off = word[B_OVFD];
  assign dis.dz_off  = word[B_DZED];
  assign dis.inv_off = word[B_INVD];

  fpx_decide u_dec (
    .dis(dis), .flags(evt_flags), .dflt_ok(evt_dflt_ok),
    .trap(d_trap), .subst(d_subst)
  );

  fpx_outreg #(.DW(3)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(evt_valid), .in_ready(evt_ready),
    .in_data({d_trap, d_subst}),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_data(held)
  );

  assign res_trap  = held[2];
  assign res_subst = held[1:0];
  assign sw_rdata  = word;
  assign rnd_mode  = word[B_RND +: 2];
endmodule

// File: rtl/fpx_trap_ctl_chk.sv
module fpx_trap_ctl_chk
  import fpx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic [WORD_W-1:0] sw_rdata,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [NFLAG-1:0]  evt_flags,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_trap,
  input logic [1:0]        res_subst
);
  localparam logic [WORD_W-1:0] MASK = WORD_W'(live_mask());

  assert_dead_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata & ~MASK) == '0);

  assert_inv_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && evt_flags[F_INV] && !sw_we) |=> sw_rdata[FLAG_LO + F_INV]);

  assert_unf_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && sw_rdata[FLAG_LO + F_UNF]) |=> sw_rdata[FLAG_LO + F_UNF]);

  assert_trap_no_subst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_trap) |-> (res_subst == SUB_NONE));

  assert_subst_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_subst != 2'd3));

  assert_stall_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !evt_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_trap) && $stable(res_subst)));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> res_valid);
endmodule

bind fpx_trap_ctl fpx_trap_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_rdata(sw_rdata),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_flags(evt_flags),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_trap(res_trap), .res_subst(res_subst)
);

// File: tb/test_fpx_trap_ctl.sv
module test_fpx_trap_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;
  localparam logic [63:0] LIVE = 64'h3FFE_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_we;
  logic [63:0] sw_wdata;
  logic [63:0] sw_rdata;
  logic        evt_valid, evt_ready;
  logic [5:0]  evt_flags;
  logic        evt_dflt_ok;
  logic        res_valid, res_ready, res_trap;
  logic [1:0]  res_subst, rnd_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] m_word;
  logic        m_ov;
  logic [2:0]  m_res;
  string       m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_trap_ctl i_fpx_trap_ctl (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_flags(evt_flags), .evt_dflt_ok(evt_dflt_ok),
    .res_valid(res_valid), .res_ready(res_ready), .res_trap(res_trap),
    .res_subst(res_subst), .rnd_mode(rnd_mode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {trap, subst}
  function automatic logic [2:0] ref_verdict(input logic [63:0] c, input logic [5:0] f, input logic dk);
    logic tr;
    logic [1:0] sb;
    tr = (f[3] && !(c[61] && c[60])) || (f[2] && !c[51]) ||
         (f[1] && !c[50]) || (f[0] && !(c[49] && dk));
    if (tr)                   sb = 2'd0;
    else if (f[3])            sb = 2'd2;
    else if (f[0]|f[1]|f[2])  sb = 2'd1;
    else                      sb = 2'd0;
    return {tr, sb};
  endfunction

  function automatic string ref_tag(input logic [5:0] f);
    if (f[3])             return "R5";
    else if (f[2] | f[1]) return "R6";
    else if (f[0])        return "R7";
    else                  return "R8";
  endfunction

  task automatic step(input logic we, input logic [63:0] wd, input logic ev,
                      input logic [5:0] fl, input logic dk, input logic rdy,
                      input string tg);
    logic        acc;
    logic [63:0] nw;
    sw_we = we; sw_wdata = wd; evt_valid = ev; evt_flags = fl;
    evt_dflt_ok = dk; res_ready = rdy;
    #1;
    check((tg != "") ? tg : "R10", {63'd0, evt_ready}, {63'd0, (!m_ov || rdy)});
    acc = ev && (!m_ov || rdy);
    nw = we ? (wd & LIVE) : m_word;
    if (acc) nw[57:52] = nw[57:52] | fl;
    @(posedge clk);
    if (acc) begin
      m_ov  = 1'b1;
      m_res = ref_verdict(m_word, fl, dk);
      m_tag = (tg != "") ? tg : ref_tag(fl);
    end else if (rdy) begin
      m_ov = 1'b0;
    end
    m_word = nw;
    @(negedge clk);
    check((tg != "") ? tg : ((acc && fl != 0) ? "R4" : "R2"), sw_rdata, m_word);
    check("R3", {62'd0, rnd_mode}, {62'd0, m_word[59:58]});
    check("R10", {63'd0, res_valid}, {63'd0, m_ov});
    if (m_ov) check(m_tag, {61'd0, res_trap, res_subst}, {61'd0, m_res});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sw_we = 0; sw_wdata = 0; evt_valid = 0; evt_flags = 0;
    evt_dflt_ok = 0; res_ready = 0;
    m_word = '0; m_ov = 0; m_res = '0; m_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", sw_rdata, 64'd0);
    check("R1", {63'd0, res_valid}, 64'd0);

    // R2: all-ones write keeps only live field bits
    step(1, '1, 0, 6'd0, 0, 1, "R2");
    // R3: each rounding encoding
    for (int k = 0; k < 4; k++) step(1, 64'(k) << 58, 0, 6'd0, 0, 1, "R3");
    // R5: the three underflow combinations
    step(1, 64'd0, 0, 0, 0, 1, "");
    step(0, 0, 1, 6'b001000, 0, 1, "R5");
    step(1, 64'h2000_0000_0000_0000, 0, 0, 0, 1, "");
    step(0, 0, 1, 6'b001000, 0, 1, "R5");
    step(1, 64'h3000_0000_0000_0000, 0, 0, 0, 1, "");
    step(0, 0, 1, 6'b001000, 0, 1, "R5");
    // R7: invalid disabled but default not producible, then producible
    step(1, 64'h0002_0000_0000_0000, 0, 0, 0, 1, "");
    step(0, 0, 1, 6'b000001, 0, 1, "R7");
    step(0, 0, 1, 6'b000001, 1, 1, "R7");
    // R8: inexact and integer overflow only
    step(0, 0, 1, 6'b110000, 0, 1, "R8");
    // R9: same-cycle write clears disable; verdict uses old word, flag still lands
    step(1, 64'd0, 1, 6'b000001, 1, 1, "R9");
    // R10: stall holds verdict and blocks intake
    step(0, 0, 1, 6'b000100, 0, 0, "R10");
    step(0, 0, 1, 6'b000010, 0, 0, "R10");
    step(0, 0, 0, 6'b000000, 0, 1, "R10");
    // R6 and general mix: random
    for (int i = 0; i < N_RAND; i++) begin
      logic        we;
      logic [63:0] wd;
      logic [5:0]  fl;
      we = ($urandom % 8) == 0;
      wd = {$urandom, $urandom};
      for (int b = 0; b < 6; b++) fl[b] = ($urandom % 4) == 0;
      step(we, wd, $urandom % 2, fl, $urandom % 2, ($urandom % 4) != 0, "");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule